// File: doc/BRIEF.md
# I2C Master Byte Transmitter

This block sends a single byte onto an I2C bus as the bus master. The byte can be payload data, a 7-bit slave address with its read/write bit in the least significant position, or either half of a 10-bit address. After the eighth bit it lets go of SDA. It then samples the slave's acknowledge at the end of the ninth clock pulse. Generating start and stop conditions, arbitration and slave clock stretching belong to neighbouring logic and are not part of this block.

A host write to the byte port loads the shift register, raises the buffer-full flag and starts the internal bit clock at once. No separate command is needed. Each SCL phase, low or high, lasts `reload + 1` system clocks. The host programs `reload` on an input port. After the ninth clock pulse the bit clock stops with SCL held low and SDA released, and a sticky completion flag is raised. The bus stays in that state until the host writes the next byte.

Any write that arrives while a byte is still shifting is refused. The refused write raises a sticky collision flag. Both SCL and SDA are open-drain: the outputs only say whether to pull the line low. SDA is read back through a configurable synchronizer.

Top module: `i2c_byte_tx`

## Requirements
- R1: Out of reset the block releases both lines (`scl_pull_low` = 0, `sda_pull_low` = 0) and clears all four host flags.
- R2: A write (`wr_en` = 1) while idle sets `buf_full` and starts a transfer. SCL is pulled low from the next clock, and SDA carries bit 7 of the written byte in that first low phase.
- R3: Each SCL low phase and each SCL high phase lasts exactly `reload + 1` clocks, with low before high. A transfer has exactly nine such clock pulses, so it lasts 18·(`reload` + 1) clocks.
- R4: Bits go out most significant first. `sda_pull_low` equals the inverse of the current bit, and SDA changes only while SCL is pulled low.
- R5: When SCL falls at the end of the eighth pulse, `buf_full` clears and SDA is released for the whole ninth pulse.
- R6: When SCL falls at the end of the ninth pulse, the synchronized SDA level is captured. `ack_stat` becomes 0 when the slave held SDA low (ACK) and 1 when SDA was high (NACK). It changes at no other time.
- R7: After the ninth pulse, `irq` is set, SCL stays pulled low and SDA stays released. This holds until the next accepted write.
- R8: A write while a transfer is in progress sets `wcol`. The written value is discarded and the byte on the bus is unaffected.
- R9: `wcol` stays set until a `clr_wcol` pulse, and `irq` stays set until a `clr_irq` pulse. If a set and a clear fall in the same cycle, the set wins.
- R10: `reload` is sampled at the start of each phase, so the host can change the bit rate between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the byte port |
| wr_data | input | DATA_W | Byte to transmit |
| reload | input | RLD_W | Phase timer reload value; one phase is reload+1 clocks |
| clr_irq | input | 1 | Pulse that clears the completion flag |
| clr_wcol | input | 1 | Pulse that clears the collision flag |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_low | output | 1 | 1 pulls SDA low, 0 releases it |
| buf_full | output | 1 | Byte loaded and not yet fully shifted |
| wcol | output | 1 | Sticky write-collision flag |
| ack_stat | output | 1 | Acknowledge status of the last transfer, 1 means NACK |
| irq | output | 1 | Sticky transfer-complete flag |

## Verification
The properties assume the host holds `reload` steady for the length of a transfer. They also assume `reload` is at least `SYNC_STAGES - 1`, so the synchronized SDA sample taken at the ninth falling edge reflects the released line and not the master's last data bit. The bench sweeps `reload` from 1 to 4 with the default two-stage synchronizer and changes `reload` only between transfers. The modelled slave holds its acknowledge level fixed for a whole transfer and combines it with the master's pull as a wired-AND. Clear pulses are given only while the block is idle, except in the case that deliberately collides a clear with a set.

// File: rtl/i2c_btx_pkg.sv
package i2c_btx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } btx_phase_e;

endpackage

// File: rtl/btx_phase_timer.sv
module btx_phase_timer #(
   parameter int RLD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [RLD_W-1:0] reload,
   output logic             expire
);

   logic [RLD_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= reload;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

endmodule

// File: rtl/btx_sequencer.sv
module btx_sequencer
   import i2c_btx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  logic              expire,
   output logic              load,
   output logic              busy,
   output logic              scl_low,
   output logic              sda_low,
   output logic              byte_sent,
   output logic              done
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] PRE_IDX  = CNT_W'(DATA_W - 1);

   btx_phase_e        phase_q;
   logic [CNT_W-1:0]  idx_q;
   logic [DATA_W-1:0] shreg_q;
   logic              scl_low_q;
   logic              sda_low_q;
   logic [DATA_W-1:0] shreg_nxt;
   logic              low_end;
   logic              high_end;

   assign shreg_nxt = {shreg_q[DATA_W-2:0], 1'b0};
   assign low_end   = (phase_q == PH_LOW)  && expire;
   assign high_end  = (phase_q == PH_HIGH) && expire;
   assign done      = high_end && (idx_q == LAST_IDX);
   assign byte_sent = high_end && (idx_q == PRE_IDX);
   assign load      = start || low_end || (high_end && !done);
   assign busy      = (phase_q != PH_IDLE);
   assign scl_low   = scl_low_q;
   assign sda_low   = sda_low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         idx_q     <= '0;
         shreg_q   <= '0;
         scl_low_q <= 1'b0;
         sda_low_q <= 1'b0;
      end else begin
         if (start) begin
            phase_q   <= PH_LOW;
            idx_q     <= '0;
            shreg_q   <= data;
            scl_low_q <= 1'b1;
            sda_low_q <= !data[DATA_W-1];
         end else if (low_end) begin
            phase_q   <= PH_HIGH;
            scl_low_q <= 1'b0;
         end else if (high_end) begin
            scl_low_q <= 1'b1;
            if (done) begin
               phase_q   <= PH_IDLE;
               sda_low_q <= 1'b0;
            end else begin
               phase_q   <= PH_LOW;
               idx_q     <= idx_q + 1'b1;
               shreg_q   <= shreg_nxt;
               sda_low_q <= byte_sent ? 1'b0 : !shreg_nxt[DATA_W-1];
            end
         end
      end
   end

endmodule

// File: rtl/btx_host_flags.sv
module btx_host_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic reject,
   input  logic byte_sent,
   input  logic done,
   input  logic ack_level,
   input  logic clr_irq,
   input  logic clr_wcol,
   output logic buf_full,
   output logic wcol,
   output logic ack_stat,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         wcol     <= 1'b0;
         ack_stat <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (accept) begin
            buf_full <= 1'b1;
         end else if (byte_sent) begin
            buf_full <= 1'b0;
         end

         if (reject) begin
            wcol <= 1'b1;
         end else if (clr_wcol) begin
            wcol <= 1'b0;
         end

         if (done) begin
            ack_stat <= ack_level;
         end

         if (done) begin
            irq <= 1'b1;
         end else if (clr_irq) begin
            irq <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx #(
   parameter int DATA_W      = 8,
   parameter int RLD_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [RLD_W-1:0]  reload,
   input  logic              clr_irq,
   input  logic              clr_wcol,
   input  logic              sda_in,
   output logic              scl_pull_low,
   output logic              sda_pull_low,
   output logic              buf_full,
   output logic              wcol,
   output logic              ack_stat,
   output logic              irq
);

   localparam int CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("i2c_byte_tx: DATA_W must be at least 2");
   end
   if (RLD_W < 1) begin : g_bad_rld_w
      $error("i2c_byte_tx: RLD_W must be at least 1");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("i2c_byte_tx: SYNC_STAGES must be within 0..4");
   end

   logic busy_w;
   logic done_w;
   logic sent_w;
   logic load_w;
   logic expire_w;
   logic accept_w;
   logic reject_w;
   logic sda_sync;

   assign accept_w = wr_en && !busy_w;
   assign reject_w = wr_en && busy_w;

   if (SYNC_STAGES == 0) begin : g_sync_none
      assign sda_sync = sda_in;
   end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] pipe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pipe_q <= '1;
         end else begin
            pipe_q[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               pipe_q[i] <= pipe_q[i-1];
            end
         end
      end
      assign sda_sync = pipe_q[SYNC_STAGES-1];
   end

   btx_phase_timer #(
      .RLD_W (RLD_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_w),
      .reload (reload),
      .expire (expire_w)
   );

   btx_sequencer #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept_w),
      .data      (wr_data),
      .expire    (expire_w),
      .load      (load_w),
      .busy      (busy_w),
      .scl_low   (scl_pull_low),
      .sda_low   (sda_pull_low),
      .byte_sent (sent_w),
      .done      (done_w)
   );

   btx_host_flags u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept_w),
      .reject    (reject_w),
      .byte_sent (sent_w),
      .done      (done_w),
      .ack_level (sda_sync),
      .clr_irq   (clr_irq),
      .clr_wcol  (clr_wcol),
      .buf_full  (buf_full),
      .wcol      (wcol),
      .ack_stat  (ack_stat),
      .irq       (irq)
   );

endmodule

// File: rtl/btx_checker.sv
module btx_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic clr_irq,
   input logic clr_wcol,
   input logic scl_pull_low,
   input logic sda_pull_low,
   input logic buf_full,
   input logic wcol,
   input logic ack_stat,
   input logic irq,
   input logic busy,
   input logic done
);

   // R2
   accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy) |=> (buf_full && busy && scl_pull_low));

   // R4
   sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_low) |-> scl_pull_low);

   // R5
   full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(buf_full) |-> (busy && !sda_pull_low && scl_pull_low));

   // R6
   ack_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ack_stat) |-> $past(done));

   // R7
   finish_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (irq && scl_pull_low && !sda_pull_low && !busy));

   // R8
   collide_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> wcol);

   // R9
   wcol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol && !clr_wcol) |=> wcol);

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_irq) |=> irq);

endmodule

bind i2c_byte_tx btx_checker u_btx_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .clr_irq      (clr_irq),
   .clr_wcol     (clr_wcol),
   .scl_pull_low (scl_pull_low),
   .sda_pull_low (sda_pull_low),
   .buf_full     (buf_full),
   .wcol         (wcol),
   .ack_stat     (ack_stat),
   .irq          (irq),
   .busy         (busy_w),
   .done         (done_w)
);

// File: tb/tb_i2c_byte_tx.sv
module tb_i2c_byte_tx;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [RW-1:0] reload = '0;
   logic          clr_irq = 1'b0;
   logic          clr_wcol = 1'b0;
   logic          slave_pull = 1'b0;
   logic          sda_in;
   logic          scl_pull_low, sda_pull_low, buf_full, wcol, ack_stat, irq;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_in = !sda_pull_low && !slave_pull;

   i2c_byte_tx #(.DATA_W(DW), .RLD_W(RW), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .reload(reload), .clr_irq(clr_irq), .clr_wcol(clr_wcol),
      .sda_in(sda_in), .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
      .buf_full(buf_full), .wcol(wcol), .ack_stat(ack_stat), .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic pulse_clears(input bit ci, input bit cw);
      @(negedge clk);
      clr_irq = ci;
      clr_wcol = cw;
      @(negedge clk);
      clr_irq = 1'b0;
      clr_wcol = 1'b0;
   endtask

   // Sends one byte and checks every cycle against the arithmetic model.
   task automatic send(input logic [DW-1:0] d, input int r, input bit ack, input bit collide);
      int ph;
      int total;
      ph = r + 1;
      total = 18 * ph;
      reload = RW'(r);
      slave_pull = ack;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      for (int t = 0; t <= total; t++) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (t < total) begin
            int bi;
            bit hi;
            bit exp_sda;
            bi = t / (2 * ph);
            hi = (t % (2 * ph)) >= ph;
            exp_sda = (bi < 8) ? !d[7 - bi] : 1'b0;
            // R3: phase length and order
            chk(scl_pull_low == !hi, "R3 scl phase", scl_pull_low, !hi);
            // R4 MSB-first data, R5 release during ninth pulse
            chk(sda_pull_low == exp_sda, (bi < 8) ? "R4 sda bit" : "R5 sda released",
                sda_pull_low, exp_sda);
            // R2 / R5: buffer-full window
            chk(buf_full == (bi < 8), (bi < 8) ? "R2 buf_full set" : "R5 buf_full clear",
                buf_full, bi < 8);
            if (collide && t == 5) begin
               wr_en = 1'b1;
               wr_data = ~d;
            end
            if (collide && t == 6) begin
               // R8
               chk(wcol == 1'b1, "R8 wcol set", wcol, 1);
            end
         end else begin
            // R7 and R6
            chk(irq == 1'b1, "R7 irq set", irq, 1);
            chk(scl_pull_low == 1'b1, "R7 scl held low", scl_pull_low, 1);
            chk(sda_pull_low == 1'b0, "R7 sda released", sda_pull_low, 0);
            chk(ack_stat == !ack, "R6 ack_stat", ack_stat, !ack);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1
      chk(scl_pull_low == 0, "R1 scl reset", scl_pull_low, 0);
      chk(sda_pull_low == 0, "R1 sda reset", sda_pull_low, 0);
      chk({buf_full, wcol, ack_stat, irq} == 4'b0, "R1 flags reset",
          {buf_full, wcol, ack_stat, irq}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: sweep of reload values with several byte patterns
      for (int r = 1; r <= 4; r++) begin
         for (int p = 0; p < 8; p++) begin
            logic [DW-1:0] pat;
            case (p)
               0: pat = 8'h00;
               1: pat = 8'hFF;
               2: pat = 8'hA5;
               3: pat = 8'h5A;
               4: pat = 8'h80;
               5: pat = 8'h01;
               6: pat = DW'(8'h3C ^ (r * 17));
               default: pat = DW'((r * 37 + 11) & 8'hFF);
            endcase
            pulse_clears(1'b1, 1'b0);
            chk(irq == 0, "R9 irq cleared", irq, 0);
            send(pat, r, p[0], 1'b0);
         end
      end

      // R7: line state held until the next write
      repeat (6) begin
         @(negedge clk);
         chk(scl_pull_low == 1 && sda_pull_low == 0 && irq == 1, "R7 idle hold",
             {scl_pull_low, sda_pull_low}, 2);
      end

      // R8: collision leaves the byte on the bus unchanged
      pulse_clears(1'b1, 1'b0);
      send(8'hC3, 2, 1'b1, 1'b1);
      // R9: wcol sticky across idle cycles
      repeat (4) begin
         @(negedge clk);
         chk(wcol == 1, "R9 wcol sticky", wcol, 1);
      end
      pulse_clears(1'b0, 1'b1);
      chk(wcol == 0, "R9 wcol cleared", wcol, 0);

      // R9: set beats clear in the same cycle
      pulse_clears(1'b1, 1'b0);
      reload = 8'd1;
      slave_pull = 1'b0;
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'h96;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      wr_en = 1'b1;
      clr_wcol = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      clr_wcol = 1'b0;
      chk(wcol == 1, "R9 set wins over clear", wcol, 1);
      // transfer started at t=0; done edge at t=36; we are at t=2
      repeat (33) @(negedge clk);
      chk(irq == 0, "R9 irq before done", irq, 0);
      clr_irq = 1'b1;
      @(negedge clk);
      clr_irq = 1'b0;
      chk(irq == 1, "R9 irq set wins over clear", irq, 1);
      chk(ack_stat == 1, "R6 nack captured", ack_stat, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule